// File: doc/BRIEF.md
# Four-Slot Descriptor and Completion Report Rings

This block sits between a 32-bit register bus and one channel of a DMA engine. Software builds each transfer descriptor by writing four words in a row to one push register. Once the fourth word lands, the whole descriptor becomes an entry in a four-slot descriptor ring, and the engine takes it with a valid/ready handshake. When the engine finishes a descriptor, it hands back a four-word completion report through a second handshake. That report goes into a four-slot report ring, and software empties it by reading one pop register four times.

Each ring has a status word. It shows the write slot, the read slot, full and empty flags, and a sticky error flag that software clears by writing a one to it. A descriptor that arrives while its ring is full is dropped and raises the descriptor error. A pop read while the report ring is empty returns zero and raises the report error. A control bit holds both rings in reset. While it is held, the rings, the word positions and the error flags are cleared. Writing zero to the bit releases it.

Two word-position state machines, one per ring, step through the states SEQ_W0, SEQ_W1, SEQ_W2 and SEQ_W3. Each accepted word moves the machine forward by one state: SEQ_W0 to SEQ_W1, SEQ_W1 to SEQ_W2, SEQ_W2 to SEQ_W3, and SEQ_W3 back to SEQ_W0. The return to SEQ_W0 commits or releases a whole entry. The ring reset forces both machines to SEQ_W0.

Top module: `desc_report_rings`

## Requirements
- R1: A status read returns the write slot in bits 1:0, the read slot in bits 5:4, empty in bit 8, full in bit 9 and error in bit 10, with every other bit zero. The register map is: 0 control, 1 descriptor status, 2 report status, 3 descriptor push, 4 report pop.
- R2: Four writes to register 3 are taken, in order, as address low, address high, byte length and flags. The cycle after the fourth write, the descriptor appears on the engine outputs and the write slot has advanced by one.
- R3: `desc_notify` equals bit 16 of the flags word of the head descriptor.
- R4: A descriptor leaves the ring only when `desc_valid` and `desc_ready` are both high. Until then the head stays stable, and descriptors leave in the order they were pushed.
- R5: After four descriptors the ring reports full with equal slot indices. A fifth descriptor is dropped, sets the descriptor error and leaves the ring contents unchanged.
- R6: Writing a status register with bit 10 set clears that ring's error flag. Writing it with bit 10 clear leaves the flag as it is.
- R7: `rpt_ready` is high exactly when the report ring is not full and not held in reset. A report is stored only when `rpt_valid` and `rpt_ready` are both high.
- R8: Four reads of register 4 return count low, count high, the auxiliary word and flags, in that order. The read slot advances after the fourth read.
- R9: A read of register 4 while the report ring is empty returns zero, sets the report error and leaves both slot indices unchanged.
- R10: Writing 1 to bit 0 of register 0 empties both rings, restarts both word positions and clears both errors. Bus and engine pushes are ignored until 0 is written.
- R11: When the slot indices differ, the ring holds (write − read + 4) mod 4 entries.
- R12: After reset both status words read 0x100, `desc_valid` is low and `rpt_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| desc_valid | output | 1 | Head descriptor available to the engine |
| desc_ready | input | 1 | Engine takes the head descriptor |
| desc_addr | output | 64 | Head descriptor buffer address |
| desc_len | output | 32 | Head descriptor byte length |
| desc_flags | output | 32 | Head descriptor flags word |
| desc_notify | output | 1 | Head descriptor asks for a completion report |
| rpt_valid | input | 1 | Engine offers a completion report |
| rpt_ready | output | 1 | Report ring can accept a report |
| rpt_count | input | 64 | Report transfer count |
| rpt_aux | input | 32 | Report auxiliary word |
| rpt_flags | input | 32 | Report flags word |

## Verification
The assertions assume the following about the inputs:
- A bus read and a bus write never share a cycle.
- The engine holds `desc_ready` and `rpt_valid` only as single-cycle pulses issued between bus accesses.
- Reset is released only on a clock edge.

The stimulus drives every input on the falling edge and raises one strobe at a time. Each bus access lasts exactly one cycle. Engine pops and report pushes are separate one-cycle tasks, so no assertion ever sees a push and a ring reset in the same cycle.

// File: rtl/dring_pkg.sv
package dring_pkg;
    localparam int WORD_W  = 32;
    localparam int SLOTS   = 4;
    localparam int IDX_W   = $clog2(SLOTS);
    localparam int ENTRY_W = 4 * WORD_W;

    // status word bit positions, decoded by software
    localparam int ST_RD_LSB  = 4;
    localparam int ST_EMPTY   = 8;
    localparam int ST_FULL    = 9;
    localparam int ST_ERR     = 10;
    localparam int NOTIFY_BIT = 16;

    typedef enum logic [2:0] {
        REG_CTRL      = 3'd0,
        REG_DESC_STAT = 3'd1,
        REG_RPT_STAT  = 3'd2,
        REG_DESC_PUSH = 3'd3,
        REG_RPT_POP   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        SEQ_W0 = 2'd0,
        SEQ_W1 = 2'd1,
        SEQ_W2 = 2'd2,
        SEQ_W3 = 2'd3
    } word_pos_e;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic [IDX_W-1:0] wr,
        input logic [IDX_W-1:0] rd,
        input logic             empty,
        input logic             full,
        input logic             err
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[IDX_W-1:0]                 = wr;
        w[ST_RD_LSB +: IDX_W]        = rd;
        w[ST_EMPTY]                  = empty;
        w[ST_FULL]                   = full;
        w[ST_ERR]                    = err;
        return w;
    endfunction
endpackage

// File: rtl/dring_store.sv
module dring_store #(
    parameter int WIDTH = 128,
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     push,
    input  logic [WIDTH-1:0]         push_data,
    input  logic                     pop,
    output logic [WIDTH-1:0]         head,
    output logic [$clog2(SLOTS)-1:0] wr_idx,
    output logic [$clog2(SLOTS)-1:0] rd_idx,
    output logic                     full,
    output logic                     empty
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [WIDTH-1:0] mem [SLOTS];
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CNT_W'(SLOTS));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_idx <= wr_idx + 1'b1;
            if (do_pop)  rd_idx <= rd_idx + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_idx] <= push_data;
    end
endmodule

// File: rtl/dring_word_seq.sv
module dring_word_seq
    import dring_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      step,
    output word_pos_e pos,
    output logic      last
);
    word_pos_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= SEQ_W0;
        else if (clr) state <= SEQ_W0;
        else          state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (step) begin
            unique case (state)
                SEQ_W0: state_nx = SEQ_W1;
                SEQ_W1: state_nx = SEQ_W2;
                SEQ_W2: state_nx = SEQ_W3;
                SEQ_W3: state_nx = SEQ_W0;
            endcase
        end
    end

    always_comb begin
        pos  = state;
        last = (state == SEQ_W3);
    end
endmodule

// File: rtl/desc_report_rings.sv
module desc_report_rings
    import dring_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        desc_valid,
    input  logic        desc_ready,
    output logic [63:0] desc_addr,
    output logic [31:0] desc_len,
    output logic [31:0] desc_flags,
    output logic        desc_notify,
    input  logic        rpt_valid,
    output logic        rpt_ready,
    input  logic [63:0] rpt_count,
    input  logic [31:0] rpt_aux,
    input  logic [31:0] rpt_flags
);
    logic               rings_rst;
    logic               desc_err, rpt_err;
    logic [WORD_W-1:0]  stage0, stage1, stage2;

    logic [ENTRY_W-1:0] desc_head, rpt_head;
    logic [IDX_W-1:0]   desc_wr, desc_rd, rpt_wr, rpt_rd;
    logic               desc_full, desc_empty, rpt_full, rpt_empty;
    word_pos_e          desc_pos, rpt_pos;
    logic               desc_last, rpt_last;

    logic ctrl_wr, desc_st_wr, rpt_st_wr;
    logic desc_word_acc, desc_commit, desc_ovf, desc_pop;
    logic rpt_read_acc, rpt_under, rpt_step, rpt_release, rpt_push;

    assign ctrl_wr       = bus_wr && (bus_addr == REG_CTRL);
    assign desc_st_wr    = bus_wr && (bus_addr == REG_DESC_STAT);
    assign rpt_st_wr     = bus_wr && (bus_addr == REG_RPT_STAT);
    assign desc_word_acc = bus_wr && (bus_addr == REG_DESC_PUSH) && !rings_rst;
    assign desc_commit   = desc_word_acc && desc_last;
    assign desc_ovf      = desc_commit && desc_full;
    assign rpt_read_acc  = bus_rd && (bus_addr == REG_RPT_POP) && !rings_rst;
    assign rpt_under     = rpt_read_acc && rpt_empty;
    assign rpt_step      = rpt_read_acc && !rpt_empty;
    assign rpt_release   = rpt_step && rpt_last;

    assign desc_valid  = !desc_empty && !rings_rst;
    assign desc_pop    = desc_valid && desc_ready;
    assign rpt_ready   = !rpt_full && !rings_rst;
    assign rpt_push    = rpt_valid && rpt_ready;

    assign desc_addr   = desc_head[2*WORD_W-1:0];
    assign desc_len    = desc_head[3*WORD_W-1:2*WORD_W];
    assign desc_flags  = desc_head[4*WORD_W-1:3*WORD_W];
    assign desc_notify = desc_flags[NOTIFY_BIT];

    dring_word_seq u_desc_seq (
        .clk(clk), .rst_n(rst_n), .clr(rings_rst), .step(desc_word_acc),
        .pos(desc_pos), .last(desc_last)
    );

    dring_word_seq u_rpt_seq (
        .clk(clk), .rst_n(rst_n), .clr(rings_rst), .step(rpt_step),
        .pos(rpt_pos), .last(rpt_last)
    );

    dring_store #(.WIDTH(ENTRY_W), .SLOTS(SLOTS)) u_desc_ring (
        .clk(clk), .rst_n(rst_n), .clr(rings_rst),
        .push(desc_commit), .push_data({bus_wdata, stage2, stage1, stage0}),
        .pop(desc_pop), .head(desc_head),
        .wr_idx(desc_wr), .rd_idx(desc_rd), .full(desc_full), .empty(desc_empty)
    );

    dring_store #(.WIDTH(ENTRY_W), .SLOTS(SLOTS)) u_rpt_ring (
        .clk(clk), .rst_n(rst_n), .clr(rings_rst),
        .push(rpt_push), .push_data({rpt_flags, rpt_aux, rpt_count}),
        .pop(rpt_release), .head(rpt_head),
        .wr_idx(rpt_wr), .rd_idx(rpt_rd), .full(rpt_full), .empty(rpt_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rings_rst <= 1'b0;
            desc_err  <= 1'b0;
            rpt_err   <= 1'b0;
            stage0    <= '0;
            stage1    <= '0;
            stage2    <= '0;
        end else begin
            if (ctrl_wr) rings_rst <= bus_wdata[0];

            if (rings_rst)                         desc_err <= 1'b0;
            else if (desc_ovf)                     desc_err <= 1'b1;
            else if (desc_st_wr && bus_wdata[ST_ERR]) desc_err <= 1'b0;

            if (rings_rst)                         rpt_err <= 1'b0;
            else if (rpt_under)                    rpt_err <= 1'b1;
            else if (rpt_st_wr && bus_wdata[ST_ERR])  rpt_err <= 1'b0;

            if (desc_word_acc) begin
                unique case (desc_pos)
                    SEQ_W0:  stage0 <= bus_wdata;
                    SEQ_W1:  stage1 <= bus_wdata;
                    SEQ_W2:  stage2 <= bus_wdata;
                    SEQ_W3:  stage2 <= stage2;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                REG_CTRL:      bus_rdata = {31'b0, rings_rst};
                REG_DESC_STAT: bus_rdata = pack_status(desc_wr, desc_rd, desc_empty, desc_full, desc_err);
                REG_RPT_STAT:  bus_rdata = pack_status(rpt_wr, rpt_rd, rpt_empty, rpt_full, rpt_err);
                REG_RPT_POP: begin
                    if (rpt_step) begin
                        unique case (rpt_pos)
                            SEQ_W0: bus_rdata = rpt_head[WORD_W-1:0];
                            SEQ_W1: bus_rdata = rpt_head[2*WORD_W-1:WORD_W];
                            SEQ_W2: bus_rdata = rpt_head[3*WORD_W-1:2*WORD_W];
                            SEQ_W3: bus_rdata = rpt_head[4*WORD_W-1:3*WORD_W];
                        endcase
                    end
                end
                default:       bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dring_chk.sv
module dring_chk
    import dring_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        desc_valid,
    input logic        desc_ready,
    input logic [63:0] desc_addr,
    input logic        rings_rst,
    input logic        desc_full,
    input logic        desc_empty,
    input logic        rpt_empty,
    input logic        rpt_err
);
    // R10
    ring_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rings_rst |=> (!desc_valid && rpt_empty));

    // R4
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready && !rings_rst) |=> (desc_valid && $stable(desc_addr)));

    // R9
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_RPT_POP && !rings_rst && rpt_empty) |=> rpt_err);

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_RPT_POP && rpt_empty) |-> (bus_rdata == 32'h0));

    // R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_full && desc_empty));
endmodule

bind desc_report_rings dring_chk u_dring_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .rings_rst(rings_rst), .desc_full(desc_full),
    .desc_empty(desc_empty), .rpt_empty(rpt_empty), .rpt_err(rpt_err)
);

// File: tb/tb_desc_report_rings.sv
`timescale 1ns/1ps
module tb_desc_report_rings;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        desc_valid, desc_ready = 1'b0, desc_notify;
    logic [63:0] desc_addr;
    logic [31:0] desc_len, desc_flags;
    logic        rpt_valid = 1'b0, rpt_ready;
    logic [63:0] rpt_count = '0;
    logic [31:0] rpt_aux = '0, rpt_flags = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    desc_report_rings dut (.*);

    localparam logic [127:0] VEC [6] = '{
        {32'h0001_0000, 32'h0000_0100, 32'h0000_0000, 32'h1000_0000},
        {32'h0000_0000, 32'h0000_0040, 32'h0000_0001, 32'h2000_0800},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h0000_0003, 32'h0000_1000, 32'h0000_00AB, 32'hCDEF_0000},
        {32'h0001_0001, 32'h0000_0010, 32'h1234_5678, 32'h9ABC_DEF0},
        {32'hFFFE_FFFF, 32'h0000_0004, 32'h8000_0000, 32'h0000_0004}
    };

    function automatic logic [31:0] st(input int wr, input int rd,
                                       input bit e, input bit f, input bit er);
        return 32'(wr) | (32'(rd) << 4) | (32'(e) << 8) | (32'(f) << 9) | (32'(er) << 10);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_desc(input logic [127:0] v);
        wr(3'd3, v[127:96]);
        wr(3'd3, v[95:64]);
        wr(3'd3, v[63:32]);
        wr(3'd3, v[31:0]);
    endtask

    task automatic pop_desc();
        @(negedge clk); desc_ready = 1'b1;
        @(negedge clk); desc_ready = 1'b0;
    endtask

    task automatic push_rpt(input logic [63:0] c, input logic [31:0] a, input logic [31:0] f);
        @(negedge clk);
        rpt_valid = 1'b1; rpt_count = c; rpt_aux = a; rpt_flags = f;
        @(negedge clk);
        rpt_valid = 1'b0;
    endtask

    function automatic logic [127:0] mk(input int i);
        return {32'hA000_0000 + 32'(i), 32'h0000_0000 + 32'(i), 32'h100 * 32'(i + 1), 32'h0001_0000 * 32'(i & 1)};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 / R1 reset state
        rd(3'd1, d); chk("R12 desc status", d, 32'h100);
        rd(3'd2, d); chk("R12 rpt status", d, 32'h100);
        chk("R12 desc_valid", desc_valid, 0);
        chk("R12 rpt_ready", rpt_ready, 1);

        // R2 R3 R4 table walk: {lo, hi, len, flags}
        for (int i = 0; i < 6; i++) begin
            push_desc(VEC[i]);
            rd(3'd1, d); chk("R1 status after push", d, st((i + 1) % 4, i % 4, 0, 0, 0));
            chk("R2 valid", desc_valid, 1);
            chk("R2 addr", desc_addr, {VEC[i][95:64], VEC[i][127:96]});
            chk("R2 len", desc_len, VEC[i][63:32]);
            chk("R2 flags", desc_flags, VEC[i][31:0]);
            chk("R3 notify", desc_notify, VEC[i][16]);
            pop_desc();
            chk("R4 empty after pop", desc_valid, 0);
        end

        // R11 R5 fill and overflow, indices start at 2
        push_desc(mk(0));
        push_desc(mk(1));
        rd(3'd1, d); chk("R11 two entries wrap", d, st(0, 2, 0, 0, 0));
        push_desc(mk(2));
        push_desc(mk(3));
        rd(3'd1, d); chk("R5 full", d, st(2, 2, 0, 1, 0));
        push_desc(mk(9));
        rd(3'd1, d); chk("R5 overflow error", d, st(2, 2, 0, 1, 1));
        repeat (3) @(negedge clk);
        chk("R4 head stable", desc_addr, {mk(0)[95:64], mk(0)[127:96]});
        for (int k = 0; k < 4; k++) begin
            chk("R4 order", desc_len, mk(k)[63:32]);
            pop_desc();
        end
        rd(3'd1, d); chk("R5 empty after drain", d, st(2, 2, 1, 0, 1));

        // R6 write-one-to-clear
        wr(3'd1, 32'h0000_03FF);
        rd(3'd1, d); chk("R6 zero keeps error", d, st(2, 2, 1, 0, 1));
        wr(3'd1, 32'h0000_0400);
        rd(3'd1, d); chk("R6 one clears error", d, st(2, 2, 1, 0, 0));

        // R9 empty report read
        rd(3'd4, d); chk("R9 empty read value", d, 0);
        rd(3'd2, d); chk("R9 underflow flag", d, st(0, 0, 1, 0, 1));
        wr(3'd2, 32'h0000_0400);
        rd(3'd2, d); chk("R6 rpt clear", d, st(0, 0, 1, 0, 0));

        // R7 R8 report push and drain
        push_rpt(64'h1111_2222_3333_4444, 32'h5555_6666, 32'h7777_8888);
        rd(3'd2, d); chk("R7 one report", d, st(1, 0, 0, 0, 0));
        rd(3'd4, d); chk("R8 count low", d, 32'h3333_4444);
        rd(3'd4, d); chk("R8 count high", d, 32'h1111_2222);
        rd(3'd2, d); chk("R8 slot held mid entry", d, st(1, 0, 0, 0, 0));
        rd(3'd4, d); chk("R8 aux", d, 32'h5555_6666);
        rd(3'd4, d); chk("R8 flags", d, 32'h7777_8888);
        rd(3'd2, d); chk("R8 released", d, st(1, 1, 1, 0, 0));
        for (int k = 0; k < 4; k++) push_rpt(64'(k), 32'(k), 32'(k));
        rd(3'd2, d); chk("R7 full", d, st(1, 1, 0, 1, 0));
        chk("R7 ready low when full", rpt_ready, 0);
        push_rpt(64'hDEAD, 32'hDEAD, 32'hDEAD);
        rd(3'd4, d); chk("R7 extra ignored head", d, 32'h0);

        // R10 ring reset mid descriptor
        wr(3'd3, 32'hBAD0_0001);
        wr(3'd3, 32'hBAD0_0002);
        wr(3'd0, 32'h1);
        chk("R10 valid low in reset", desc_valid, 0);
        chk("R10 ready low in reset", rpt_ready, 0);
        rd(3'd1, d); chk("R10 desc cleared", d, 32'h100);
        rd(3'd2, d); chk("R10 rpt cleared", d, 32'h100);
        push_desc(mk(5));
        rd(3'd1, d); chk("R10 push ignored", d, 32'h100);
        wr(3'd0, 32'h0);
        push_desc(mk(6));
        rd(3'd1, d); chk("R10 after release", d, st(1, 0, 0, 0, 0));
        chk("R10 word position restarted", desc_addr, {mk(6)[95:64], mk(6)[127:96]});
        chk("R10 len", desc_len, mk(6)[63:32]);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule